// File: doc/BRIEF.md
# Glitch-Free Smartcard Clock Generator

This block produces the clock for one smartcard slot. It runs on a fast system clock and treats the card's external input clock and a roughly 1.2 MHz internal clock as sampled levels. It drives the card clock pin from one of four sources: the external clock divided by a selectable ratio, the internal clock, a constant low, or a constant high. An eight-bit configuration write selects the source and the ratio. Requests that the permitted-transition rules forbid are dropped. Every change of source or ratio waits for a cycle in which the old and new waveforms agree, so the pin never carries a shortened pulse.

A status output rises in the same cycle that the internal clock reaches the pin. While an activation is in progress, a request for the internal clock is held at the divided clock, and the switch is made once activation ends. A synchronous-mode override bypasses all of this logic. It sends either the raw external clock or a stored static level straight to the pin.

Top module: `sclk_gen`

## Requirements
- R1: While `rst` is high, `card_clk` and `int_clk_on` are 0. After reset the block is in divided mode at ratio /1, and `card_clk` equals the value that `ext_clk` had one system-clock cycle earlier.
- R2: In divided mode, `wr_data[4:2]` selects the ratio: 000=/1, 001=/2, 010=/4, 011=/5, 100=/8. The codes 101, 110 and 111 select /1.
- R3: The output duty cycle is 50% at /2, /4 and /8. At /1 it equals the input duty cycle n. At /5 it is (n+2)/5.
- R4: `wr_data[7]` requests internal mode, `wr_data[6]` requests static high and `wr_data[5]` requests static low, with priority in that order. All three clear requests divided mode. Divided mode may move to any mode. The internal and static modes may move only to divided mode. A forbidden request is ignored, and the output keeps its current mode.
- R5: A write with any of `wr_data[7:5]` set leaves the stored ratio field unchanged.
- R6: A change from divided mode to a static level happens in a cycle where both the divided level and `ext_clk` equal that level. A change from a static level back to divided mode happens in a cycle where the divided level equals the static level.
- R7: A new ratio takes effect only at a rising edge of the divided output.
- R8: A change into or out of internal mode happens only in a cycle where `int_clk` and the divided output both rise.
- R9: `int_clk_on` is 1 exactly when the pin carries the internal clock. It rises in the same cycle that the internal clock first appears on `card_clk`.
- R10: While `act_busy` is 1, a request for internal mode keeps the pin on the divided clock at the stored ratio. The switch to the internal clock is made after `act_busy` falls.
- R11: When `sync_mode` and `sync_clk_en` are both 1, `card_clk` equals `ext_clk` delayed by one cycle, whatever the mode.
- R12: When `sync_mode` is 1 and `sync_clk_en` is 0, `card_clk` equals bit 6 of the most recent write.
- R13: Outside synchronous mode, no high or low run on `card_clk` is shorter than the shortest high or low phase of its sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Sampled external card input clock |
| int_clk | input | 1 | Sampled internal clock |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration write value |
| act_busy | input | 1 | Card activation in progress |
| sync_mode | input | 1 | Synchronous-mode override enable |
| sync_clk_en | input | 1 | In synchronous mode, pass the raw external clock |
| card_clk | output | 1 | Card clock output |
| int_clk_on | output | 1 | Internal clock is present on the output |

## Verification
A wrong divider count or a wrongly applied ratio shows up within one output period as the wrong number of rising edges or high cycles over a fixed window. A bad mode register or transition decision keeps the pin static, or keeps it toggling, after a request that should have been dropped or honoured. A switch taken in the wrong cycle leaves a one-cycle runt that the run-length monitor catches. A status flag out of step with the selected source shows at the next sample. If the edge-alignment logic fails, the internal clock never reaches the pin, so both the edge count and the flag are wrong.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  localparam int REG_W = 8;
  localparam int SEL_W = 3;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    M_DIV = 2'd0,
    M_INT = 2'd1,
    M_LO  = 2'd2,
    M_HI  = 2'd3
  } clk_mode_e;

  // last counter value of one output period for a ratio code
  function automatic logic [CNT_W-1:0] ratio_last(input logic [SEL_W-1:0] sel);
    case (sel)
      3'b001:  ratio_last = 3'd1;
      3'b010:  ratio_last = 3'd3;
      3'b011:  ratio_last = 3'd4;
      3'b100:  ratio_last = 3'd7;
      default: ratio_last = 3'd0;
    endcase
  endfunction

  function automatic clk_mode_e decode_mode(input logic [2:0] bits);
    if (bits[2])      decode_mode = M_INT;
    else if (bits[1]) decode_mode = M_HI;
    else if (bits[0]) decode_mode = M_LO;
    else              decode_mode = M_DIV;
  endfunction

  function automatic logic move_ok(input clk_mode_e from, input clk_mode_e to);
    move_ok = (from == M_DIV) || (to == M_DIV) || (from == to);
  endfunction

endpackage

// File: rtl/sclk_cfg.sv
module sclk_cfg
  import sclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [SEL_W-1:0] div_sel,
  output clk_mode_e        tgt_mode,
  output logic             sync_lvl
);

  clk_mode_e req_mode;
  logic      mode_bits_set;
  logic      unused_low;

  assign req_mode      = decode_mode(wr_data[7:5]);
  assign mode_bits_set = |wr_data[7:5];
  assign unused_low    = ^wr_data[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_sel  <= '0;
      tgt_mode <= M_DIV;
      sync_lvl <= 1'b0;
    end else if (wr_en) begin
      sync_lvl <= wr_data[6];
      if (!mode_bits_set)
        div_sel <= wr_data[4:2];
      if (move_ok(tgt_mode, req_mode))
        tgt_mode <= req_mode;
    end
  end

  // R5
  lock_field_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode_bits_set) |=> (div_sel == $past(div_sel)));

  // R4
  forbid_move_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tgt_mode != $past(tgt_mode)) |->
      (tgt_mode == M_DIV || $past(tgt_mode) == M_DIV));

endmodule

// File: rtl/sclk_div.sv
module sclk_div
  import sclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_clk,
  input  logic [SEL_W-1:0] div_sel,
  output logic             div_lvl,
  output logic             div_rise
);

  logic             ext_prev;
  logic             ext_rise;
  logic [CNT_W-1:0] cnt, cnt_nxt, last;
  logic [SEL_W-1:0] act_sel;

  assign ext_rise = ext_clk & ~ext_prev;
  assign last     = ratio_last(act_sel);
  assign div_rise = ext_rise && (cnt == last);

  always_comb begin
    cnt_nxt = cnt;
    if (ext_rise)
      cnt_nxt = (cnt == last) ? '0 : cnt + 3'd1;
  end

  always_comb begin
    case (act_sel)
      3'b001:  div_lvl = (cnt_nxt < 3'd1);
      3'b010:  div_lvl = (cnt_nxt < 3'd2);
      3'b100:  div_lvl = (cnt_nxt < 3'd4);
      3'b011:  div_lvl = (cnt_nxt < 3'd2) || ((cnt_nxt == 3'd2) && ext_clk);
      default: div_lvl = ext_clk;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev <= 1'b0;
      cnt      <= '0;
      act_sel  <= '0;
    end else begin
      ext_prev <= ext_clk;
      cnt      <= cnt_nxt;
      if (div_rise)
        act_sel <= div_sel;
    end
  end

  // R7
  ratio_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && act_sel != $past(act_sel)) |-> $past(div_rise));

  // R7
  rise_high_chk: assert property (@(posedge clk) disable iff (rst)
    div_rise |-> div_lvl);

endmodule

// File: rtl/sclk_sw.sv
module sclk_sw
  import sclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  clk_mode_e tgt_mode,
  input  logic      act_busy,
  input  logic      ext_clk,
  input  logic      int_clk,
  input  logic      div_lvl,
  input  logic      div_rise,
  output clk_mode_e cur_nxt
);

  clk_mode_e cur, eff;
  logic      int_prev, int_rise, aligned, go;

  assign int_rise = int_clk & ~int_prev;
  assign aligned  = int_rise && div_rise;
  assign eff      = (tgt_mode == M_INT && act_busy) ? M_DIV : tgt_mode;

  always_comb begin
    go = 1'b0;
    case (cur)
      M_DIV: begin
        case (eff)
          M_LO:    go = !div_lvl && !ext_clk;
          M_HI:    go = div_lvl && ext_clk;
          M_INT:   go = aligned;
          default: go = 1'b0;
        endcase
      end
      M_LO:    go = (eff != M_LO) && !div_lvl;
      M_HI:    go = (eff != M_HI) && div_lvl;
      M_INT:   go = (eff != M_INT) && aligned;
      default: go = 1'b0;
    endcase
  end

  assign cur_nxt = go ? ((cur == M_DIV) ? eff : M_DIV) : cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= M_DIV;
      int_prev <= 1'b0;
    end else begin
      cur      <= cur_nxt;
      int_prev <= int_clk;
    end
  end

  // R4
  path_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur != $past(cur)) |-> (cur == M_DIV || $past(cur) == M_DIV));

  // R6
  to_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur == M_LO && $past(cur) == M_DIV) |->
      (!$past(div_lvl) && !$past(ext_clk)));

  // R6
  to_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur == M_HI && $past(cur) == M_DIV) |->
      ($past(div_lvl) && $past(ext_clk)));

  // R8
  int_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur != $past(cur) && (cur == M_INT || $past(cur) == M_INT)) |->
      ($past(int_rise) && $past(div_rise)));

  // R10
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(act_busy) && $past(cur) != M_INT) |-> (cur != M_INT));

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_clk,
  input  logic             int_clk,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             act_busy,
  input  logic             sync_mode,
  input  logic             sync_clk_en,
  output logic             card_clk,
  output logic             int_clk_on
);

  logic [SEL_W-1:0] div_sel;
  clk_mode_e        tgt_mode, cur_nxt;
  logic             sync_lvl, div_lvl, div_rise, sel_lvl;

  sclk_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .div_sel  (div_sel),
    .tgt_mode (tgt_mode),
    .sync_lvl (sync_lvl)
  );

  sclk_div u_div (
    .clk      (clk),
    .rst      (rst),
    .ext_clk  (ext_clk),
    .div_sel  (div_sel),
    .div_lvl  (div_lvl),
    .div_rise (div_rise)
  );

  sclk_sw u_sw (
    .clk      (clk),
    .rst      (rst),
    .tgt_mode (tgt_mode),
    .act_busy (act_busy),
    .ext_clk  (ext_clk),
    .int_clk  (int_clk),
    .div_lvl  (div_lvl),
    .div_rise (div_rise),
    .cur_nxt  (cur_nxt)
  );

  always_comb begin
    case (cur_nxt)
      M_INT:   sel_lvl = int_clk;
      M_LO:    sel_lvl = 1'b0;
      M_HI:    sel_lvl = 1'b1;
      default: sel_lvl = div_lvl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      card_clk   <= 1'b0;
      int_clk_on <= 1'b0;
    end else begin
      card_clk   <= sync_mode ? (sync_clk_en ? ext_clk : sync_lvl) : sel_lvl;
      int_clk_on <= (cur_nxt == M_INT);
    end
  end

  // R11
  sync_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sync_mode) && $past(sync_clk_en)) |->
      (card_clk == $past(ext_clk)));

  // R9
  int_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sync_mode) && int_clk_on) |->
      (card_clk == $past(int_clk)));

endmodule

// File: tb/sclk_gen_tb.sv
module sclk_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk = 1'b0;
  logic       int_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       act_busy = 1'b0;
  logic       sync_mode = 1'b0;
  logic       sync_clk_en = 1'b0;
  logic       card_clk;
  logic       int_clk_on;

  always #5 clk = ~clk;

  sclk_gen dut_i (
    .clk         (clk),
    .rst         (rst),
    .ext_clk     (ext_clk),
    .int_clk     (int_clk),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .act_busy    (act_busy),
    .sync_mode   (sync_mode),
    .sync_clk_en (sync_clk_en),
    .card_clk    (card_clk),
    .int_clk_on  (int_clk_on)
  );

  // Source clocks: ext period 6 (high 2, duty 1/3), int period 8 (high 4).
  // Counted totals and the run-length monitor.
  int ext_ph = 0;
  int int_ph = 0;
  int hi_total = 0;
  int rise_total = 0;
  int runt_cnt = 0;
  int run_len = 0;
  logic run_ok = 1'b0;
  logic prev_card = 1'b0;

  always @(negedge clk) begin
    hi_total = hi_total + (card_clk ? 1 : 0);
    if (card_clk && !prev_card) rise_total = rise_total + 1;
    if (card_clk != prev_card) begin
      if (run_ok && run_len < 2) runt_cnt = runt_cnt + 1;
      run_len = 1;
      run_ok  = !(rst || sync_mode);
    end else begin
      run_len = run_len + 1;
      if (rst || sync_mode) run_ok = 1'b0;
    end
    prev_card = card_clk;
    ext_ph  = (ext_ph + 1) % 6;
    int_ph  = (int_ph + 1) % 8;
    ext_clk = (ext_ph < 2);
    int_clk = (int_ph < 4);
  end

  // Scoreboard
  typedef struct {
    string tag;
    int    val;
  } exp_t;

  exp_t  exp_q[$];
  event  res_ev;
  int    res_val;
  int    n_vec = 0;
  int    n_fail = 0;

  initial begin
    forever begin
      @(res_ev);
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: actual %0d expected none", res_val);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (res_val != e.val) begin
          n_fail++;
          $display("FAIL %s: actual %0d expected %0d", e.tag, res_val, e.val);
        end
      end
    end
  end

  task automatic push_exp(input string tag, input int v);
    exp_t e;
    e.tag = tag;
    e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic report(input int actual);
    res_val = actual;
    -> res_ev;
    #1;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // settle, then count high cycles and rising edges over 240 cycles
  task automatic measure(input string tag, input int exp_hi, input int exp_edges);
    int h0, r0;
    push_exp({tag, " high cycles"}, exp_hi);
    push_exp({tag, " rising edges"}, exp_edges);
    repeat (120) @(posedge clk);
    h0 = hi_total;
    r0 = rise_total;
    repeat (240) @(posedge clk);
    report(hi_total - h0);
    report(rise_total - r0);
  endtask

  task automatic check_flag(input string tag, input int expv);
    push_exp(tag, expv);
    @(negedge clk);
    #1;
    report(int'(int_clk_on));
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    push_exp("R1 reset card_clk", 0);
    report(int'(card_clk));
    push_exp("R1 reset int_clk_on", 0);
    report(int'(int_clk_on));
    @(negedge clk);
    rst = 1'b0;

    measure("R1 R3 after reset /1", 80, 40);
    wr(8'h04); measure("R2 R3 R7 ratio /2", 120, 20);
    wr(8'h08); measure("R2 R3 R7 ratio /4", 120, 10);
    wr(8'h0C); measure("R2 R3 R7 ratio /5", 112, 8);
    wr(8'h10); measure("R2 R3 R7 ratio /8", 120, 5);
    wr(8'h14); measure("R2 code 101 gives /1", 80, 40);

    // internal request with field /8 during activation
    wr(8'h00);
    act_busy = 1'b1;
    wr(8'h90); measure("R5 R10 held divided at stored /1", 80, 40);
    check_flag("R10 flag clear during activation", 0);

    act_busy = 1'b0;
    measure("R8 R10 internal clock on pin", 120, 30);
    check_flag("R9 flag set with internal", 1);

    wr(8'h40); measure("R4 internal to high ignored", 120, 30);
    wr(8'h20); measure("R4 internal to low ignored", 120, 30);
    check_flag("R9 flag still set", 1);

    wr(8'h00); measure("R4 R8 internal back to /1", 80, 40);
    check_flag("R9 flag cleared", 0);

    wr(8'h40); measure("R4 R6 divided to high", 240, 0);
    wr(8'h20); measure("R4 high to low ignored", 240, 0);
    wr(8'h80); measure("R4 high to internal ignored", 240, 0);
    check_flag("R4 R9 flag clear after refused internal", 0);
    wr(8'h08); measure("R4 R6 high back to /4", 120, 10);
    wr(8'h20); measure("R6 divided to low", 0, 0);
    wr(8'h0C); measure("R6 low back to /5", 112, 8);
    wr(8'h60); measure("R4 bit6 over bit5 priority", 240, 0);

    sync_mode   = 1'b1;
    sync_clk_en = 1'b1;
    measure("R11 sync raw input", 80, 40);
    sync_clk_en = 1'b0;
    measure("R12 sync level bit6 one", 240, 0);
    wr(8'h0C); measure("R12 sync level bit6 zero", 0, 0);
    sync_mode = 1'b0;
    measure("R5 R6 leave sync at /5", 112, 8);

    push_exp("R13 R6 R7 R8 runt pulses", 0);
    report(runt_cnt);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule